// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request into the string of erase commands a page-organised serial flash needs. A request gives a byte start address and a byte length. The block first divides both by the run-time page size, which need not be a power of two, and rejects the request if either value leaves a remainder. It then walks the page range. At each step it picks an eight-page block erase when the current page is block-aligned and at least eight pages remain. Otherwise it picks a single-page erase.

Each command goes out as four bytes over a byte-level SPI master port: the opcode, two address bytes and a zero byte. The address comes from shifting the page index left by a configured amount. After every command the block polls the device status until the ready bit is set, leaving a programmable idle gap between polls. Then it advances to the next step. A one-cycle done pulse or a one-cycle error pulse ends the request.

The byte port is a handshake. A byte is taken when `spi_tx_valid` and `spi_tx_ready` are both high. The shifter then returns the byte it clocked in with a one-cycle `spi_rx_valid`. The block sends nothing further until that return arrives.

Top module: `flash_erase_seq`

## Requirements
- R1: If the start address or the length is not a whole multiple of the page size, the block raises `err` for one cycle, drops `busy`, and never asserts `spi_sel`.
- R2: An aligned request of length zero ends with a `done` pulse, and no command is sent.
- R3: Each erase command uses opcode 0x50 (block erase of eight pages) when the page index is a multiple of 8 and at least 8 pages remain. In every other case it uses opcode 0x81 (single-page erase).
- R4: Each erase command is exactly four bytes, sent while `spi_sel` stays high: the opcode, then bits [23:16] of (page index << `cfg_page_shift`), then bits [15:8] of that value, then 0x00.
- R5: After each erase command, `spi_sel` drops and the block polls the device. Each poll is a separate two-byte selection: byte 0xD7, then a dummy 0x00. Bit 7 of the byte returned for the dummy is 1 when the device is ready. Polling continues until that bit reads 1.
- R6: Between two consecutive polls, `spi_sel` stays low for at least `cfg_poll_gap` clock cycles.
- R7: After a ready status, the page index advances and the remaining page count drops by 8 for a block erase or by 1 for a page erase. The request finishes when the count reaches zero.
- R8: `busy` goes high in the cycle after a request is accepted and stays high until the cycle in which `done` or `err` pulses. `done` and `err` are single-cycle pulses that never occur together. After reset, all outputs are low.
- R9: A `req_valid` seen while `busy` is high is ignored and adds no commands.
- R10: Page sizes that are not powers of two (264, 528, 1056) give the correct page index and alignment check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken when not busy |
| req_addr | input | AW | Byte start address |
| req_len | input | AW | Byte length |
| cfg_page_size | input | PSW | Page size in bytes |
| cfg_page_shift | input | 4 | Left shift from page index to device address (8..11) |
| cfg_poll_gap | input | GW | Minimum idle cycles between status polls |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse, range fully erased |
| err | output | 1 | One-cycle pulse, misaligned request |
| spi_sel | output | 1 | Chip select, active high |
| spi_tx_valid | output | 1 | Byte offered to shifter |
| spi_tx_data | output | 8 | Byte to send |
| spi_tx_ready | input | 1 | Shifter accepts byte |
| spi_rx_valid | input | 1 | Exchange complete, received byte valid |
| spi_rx_data | input | 8 | Received byte |

## Verification
A wrong page index or remaining count shows up at the port within one command. The very next erase frame carries the wrong opcode or wrong address bytes, so the bench rebuilds the full expected command list from the requirements and compares it frame by frame. A wrong ready decision shows up as too many or too few poll frames after a command, so the bench sets the number of busy replies per command and counts the polls. A gap counter that expires too early shows up as a short idle stretch between two polls. Faults in the divider or the alignment check show up in the same request, either as a spurious or missing error pulse or as a shifted address on the first command.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int         BLOCK_PAGES    = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_DIVA, S_DIVL, S_PLAN, S_XFER, S_RXW, S_DESEL, S_GAP
  } fes_state_t;
endpackage

// File: rtl/fes_divider.sv
module fes_divider #(
  parameter int NW = 24,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial;
  logic [DW:0]   diff;

  assign trial = {rem, quot[NW-1]};
  assign diff  = trial - {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      quot <= '0;
      rem  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        cnt  <= CW'(NW);
        quot <= dividend;
        rem  <= '0;
      end else if (run) begin
        if (trial >= {1'b0, divisor}) begin
          rem  <= diff[DW-1:0];
          quot <= {quot[NW-2:0], 1'b1};
        end else begin
          rem  <= trial[DW-1:0];
          quot <= {quot[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10: the remainder handed back is always below the divisor
  assert_rem_below_divisor_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem < divisor));
endmodule

// File: rtl/fes_step_plan.sv
module fes_step_plan
  import fes_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] page_idx,
  input  logic [AW-1:0] pages_left,
  input  logic [3:0]    shift,
  output logic [7:0]    opcode,
  output logic [7:0]    addr_hi,
  output logic [7:0]    addr_mid,
  output logic [3:0]    step
);
  localparam int WW = AW + 16;

  logic [WW-1:0] wide;
  logic          use_block;

  always_comb begin
    wide      = {16'b0, page_idx} << shift;
    use_block = (page_idx[2:0] == 3'b000) && (pages_left >= AW'(BLOCK_PAGES));
    opcode    = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
    step      = use_block ? 4'(BLOCK_PAGES) : 4'd1;
    addr_hi   = wide[23:16];
    addr_mid  = wide[15:8];
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int AW  = 24,
  parameter int PSW = 11,
  parameter int GW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [AW-1:0]  req_len,
  input  logic [PSW-1:0] cfg_page_size,
  input  logic [3:0]     cfg_page_shift,
  input  logic [GW-1:0]  cfg_poll_gap,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           spi_sel,
  output logic           spi_tx_valid,
  output logic [7:0]     spi_tx_data,
  input  logic           spi_tx_ready,
  input  logic           spi_rx_valid,
  input  logic [7:0]     spi_rx_data
);
  fes_state_t     st;
  logic [AW-1:0]  addr_q, len_q, page_idx, pages_left;
  logic           div_sel, div_start, div_done, addr_rem_nz;
  logic [AW-1:0]  div_quot;
  logic [PSW-1:0] div_rem;
  logic [7:0]     cmd_op, cmd_hi, cmd_mid, last_stat;
  logic [3:0]     cur_step, plan_step;
  logic [7:0]     plan_op, plan_hi, plan_mid;
  logic           polling;
  logic [1:0]     idx;
  logic [GW-1:0]  gap_cnt;
  logic           last_byte;
  logic [AW-1:0]  step_w;

  fes_divider #(.NW(AW), .DW(PSW)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .dividend(div_sel ? len_q : addr_q), .divisor(cfg_page_size),
    .done(div_done), .quot(div_quot), .rem(div_rem)
  );

  fes_step_plan #(.AW(AW)) u_plan (
    .page_idx(page_idx), .pages_left(pages_left), .shift(cfg_page_shift),
    .opcode(plan_op), .addr_hi(plan_hi), .addr_mid(plan_mid), .step(plan_step)
  );

  assign last_byte = polling ? (idx == 2'd1) : (idx == 2'd3);
  assign step_w    = AW'(cur_step);

  function automatic logic [7:0] byte_at(input logic pol, input logic [1:0] i,
                                         input logic [7:0] op, input logic [7:0] hi,
                                         input logic [7:0] mid);
    if (pol) return (i == 2'd0) ? OP_STATUS : 8'h00;
    case (i)
      2'd0:    return op;
      2'd1:    return hi;
      2'd2:    return mid;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      spi_sel <= 1'b0; spi_tx_valid <= 1'b0; spi_tx_data <= '0;
      addr_q <= '0; len_q <= '0; page_idx <= '0; pages_left <= '0;
      div_sel <= 1'b0; div_start <= 1'b0; addr_rem_nz <= 1'b0;
      cmd_op <= '0; cmd_hi <= '0; cmd_mid <= '0; cur_step <= '0;
      last_stat <= '0; polling <= 1'b0; idx <= '0; gap_cnt <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      div_start <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr; len_q <= req_len;
          busy <= 1'b1; div_sel <= 1'b0; div_start <= 1'b1; st <= S_DIVA;
        end
        S_DIVA: if (div_done) begin
          page_idx <= div_quot; addr_rem_nz <= (div_rem != '0);
          div_sel <= 1'b1; div_start <= 1'b1; st <= S_DIVL;
        end
        S_DIVL: if (div_done) begin
          pages_left <= div_quot;
          if (addr_rem_nz || div_rem != '0) begin
            err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else if (div_quot == '0) begin
            done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_PLAN;
          end
        end
        S_PLAN: begin
          cmd_op <= plan_op; cmd_hi <= plan_hi; cmd_mid <= plan_mid;
          cur_step <= plan_step; polling <= 1'b0; idx <= 2'd0;
          spi_sel <= 1'b1; spi_tx_valid <= 1'b1; spi_tx_data <= plan_op;
          st <= S_XFER;
        end
        S_XFER: if (spi_tx_ready) begin
          spi_tx_valid <= 1'b0; st <= S_RXW;
        end
        S_RXW: if (spi_rx_valid) begin
          if (last_byte) begin
            spi_sel <= 1'b0;
            if (polling) last_stat <= spi_rx_data;
            st <= S_DESEL;
          end else begin
            idx <= idx + 2'd1;
            spi_tx_valid <= 1'b1;
            spi_tx_data <= byte_at(polling, idx + 2'd1, cmd_op, cmd_hi, cmd_mid);
            st <= S_XFER;
          end
        end
        S_DESEL: begin
          if (!polling) begin
            polling <= 1'b1; idx <= 2'd0; spi_sel <= 1'b1;
            spi_tx_valid <= 1'b1; spi_tx_data <= OP_STATUS; st <= S_XFER;
          end else if (last_stat[7]) begin
            page_idx <= page_idx + step_w;
            pages_left <= pages_left - step_w;
            if (pages_left == step_w) begin
              done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
            end else begin
              st <= S_PLAN;
            end
          end else begin
            gap_cnt <= cfg_poll_gap; st <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) begin
            idx <= 2'd0; spi_sel <= 1'b1; spi_tx_valid <= 1'b1;
            spi_tx_data <= OP_STATUS; st <= S_XFER;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: a byte is only offered while the device is selected
  assert_tx_inside_sel_R4: assert property (@(posedge clk) disable iff (rst)
    spi_tx_valid |-> spi_sel);
  // R3: the first byte of an erase frame is one of the two erase opcodes
  assert_erase_opcode_R3: assert property (@(posedge clk) disable iff (rst)
    (spi_tx_valid && !polling && idx == 2'd0) |->
      (spi_tx_data == OP_BLOCK_ERASE || spi_tx_data == OP_PAGE_ERASE));
  // R8: done is a single-cycle pulse that clears busy
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R8: done and err are exclusive
  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R8: busy only rises after an accepted request
  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  // R1: an error never coincides with a selected device
  assert_err_no_sel_R1: assert property (@(posedge clk) disable iff (rst)
    err |-> !spi_sel);
  // R7: the page count never underflows on an advance
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_DESEL && polling && last_stat[7]) |-> (pages_left >= step_w));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int AW = 24, PSW = 11, GW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic [PSW-1:0] cfg_page_size = 11'd256;
  logic [3:0] cfg_page_shift = 4'd8;
  logic [GW-1:0] cfg_poll_gap = '0;
  logic busy, done, err, spi_sel, spi_tx_valid;
  logic [7:0] spi_tx_data;
  logic spi_tx_ready = 1'b0, spi_rx_valid = 1'b0;
  logic [7:0] spi_rx_data = 8'h00;

  always #5 clk = ~clk;

  flash_erase_seq #(.AW(AW), .PSW(PSW), .GW(GW)) u_flash_erase_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
    .cfg_poll_gap(cfg_poll_gap), .busy(busy), .done(done), .err(err),
    .spi_sel(spi_sel), .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
    .spi_tx_ready(spi_tx_ready), .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
  );

  int n_chk = 0, n_err = 0;
  logic clr_log = 1'b1;
  int busy_polls_cfg = 0;

  // device model and frame log
  logic sel_q = 1'b0;
  int low_cnt = 0, gap_at_start = 0, min_gap = 0;
  bit prev_poll = 1'b0;
  int n_poll = 0, bad_poll = 0, n_er = 0, fr_len = 0, poll_left = 0, pend = 0;
  logic [7:0] fr_b [0:3];
  logic [7:0] pend_data = 8'h00;
  logic [31:0] e_frame [0:63];
  int e_len [0:63];

  always @(posedge clk) begin
    sel_q <= spi_sel;
    spi_rx_valid <= 1'b0;
    spi_tx_ready <= ~spi_tx_ready;
    if (clr_log) begin
      n_er <= 0; n_poll <= 0; bad_poll <= 0; min_gap <= 1000000;
      prev_poll <= 1'b0; fr_len <= 0; pend <= 0; poll_left <= 0; low_cnt <= 0;
      for (int i = 0; i < 4; i++) fr_b[i] <= 8'h00;
    end else begin
      low_cnt <= spi_sel ? 0 : low_cnt + 1;
      if (spi_sel && !sel_q) gap_at_start <= low_cnt;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin spi_rx_valid <= 1'b1; spi_rx_data <= pend_data; end
      end
      if (spi_tx_valid && spi_tx_ready) begin
        if (fr_len < 4) fr_b[fr_len[1:0]] <= spi_tx_data;
        fr_len <= fr_len + 1;
        pend <= 2;
        if (fr_len == 1 && fr_b[0] == 8'hD7) begin
          pend_data <= (poll_left == 0) ? 8'h80 : 8'h01;
          if (poll_left != 0) poll_left <= poll_left - 1;
        end else begin
          pend_data <= 8'h3C;
        end
      end
      if (!spi_sel && sel_q) begin
        fr_len <= 0;
        if (fr_b[0] == 8'hD7) begin
          n_poll <= n_poll + 1;
          if (fr_len != 2 || fr_b[1] != 8'h00) bad_poll <= bad_poll + 1;
          if (prev_poll && gap_at_start < min_gap) min_gap <= gap_at_start;
          prev_poll <= 1'b1;
        end else begin
          if (n_er < 64) begin
            e_frame[n_er] <= {fr_b[0], fr_b[1], fr_b[2], fr_b[3]};
            e_len[n_er] <= fr_len;
          end
          n_er <= n_er + 1;
          poll_left <= busy_polls_cfg;
          prev_poll <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  bit saw_done, saw_err;

  task automatic run_req(input int addr, input int len, input int psize, input int shift,
                         input int gap, input int bpolls, input bit extra_req);
    @(negedge clk);
    cfg_page_size = PSW'(psize); cfg_page_shift = 4'(shift);
    cfg_poll_gap = GW'(gap); busy_polls_cfg = bpolls;
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    req_addr = AW'(addr); req_len = AW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    saw_done = 1'b0; saw_err = 1'b0;
    for (int t = 0; t < 40000; t++) begin
      if (extra_req && t == 60) begin
        req_addr = AW'(addr + 8 * psize); req_len = AW'(psize); req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (done || err) begin
        saw_done = done; saw_err = err;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!(saw_done && saw_err), "R8 done/err exclusive", int'(saw_err), 0);
    @(negedge clk);
    chk(!done && !err && !busy, "R8 single pulse then idle", int'({done, err, busy}), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frames(input int idx0, input int pages, input int shift,
                              input int bpolls, input int gap, input string rq);
    int idx = idx0, left = pages, k = 0;
    bit blk;
    logic [31:0] da;
    logic [31:0] exp_f;
    while (left > 0) begin
      blk = (idx % 8 == 0) && (left >= 8);
      da = 32'(idx) << shift;
      exp_f = {blk ? 8'h50 : 8'h81, da[23:16], da[15:8], 8'h00};
      if (k < 64 && k < n_er) begin
        chk(e_frame[k] == exp_f, rq, int'(e_frame[k]), int'(exp_f));
        chk(e_len[k] == 4, "R4 frame length", e_len[k], 4);
      end
      idx += blk ? 8 : 1;
      left -= blk ? 8 : 1;
      k++;
    end
    chk(n_er == k, "R7 erase command count", n_er, k);
    chk(n_poll == k * (bpolls + 1), "R5 poll count", n_poll, k * (bpolls + 1));
    chk(bad_poll == 0, "R5 poll frame format", bad_poll, 0);
    if (bpolls > 0) chk(min_gap >= gap, "R6 idle between polls", min_gap, gap);
  endtask

  task automatic t_reset;
    chk({busy, done, err, spi_sel, spi_tx_valid} == 5'b0, "R8 reset outputs",
        int'({busy, done, err, spi_sel, spi_tx_valid}), 0);
  endtask

  task automatic t_bad_addr;
    run_req(257, 256, 256, 8, 0, 0, 1'b0);
    chk(saw_err, "R1 misaligned address err", int'(saw_err), 1);
    chk(n_er == 0 && n_poll == 0, "R1 no frames on error", n_er + n_poll, 0);
  endtask

  task automatic t_bad_len;
    run_req(264 * 3, 100, 264, 9, 0, 0, 1'b0);
    chk(saw_err, "R1 R10 misaligned length err", int'(saw_err), 1);
    chk(n_er == 0 && n_poll == 0, "R1 no frames on error", n_er + n_poll, 0);
  endtask

  task automatic t_zero_len;
    run_req(512, 0, 256, 8, 0, 0, 1'b0);
    chk(saw_done, "R2 zero length done", int'(saw_done), 1);
    chk(n_er == 0 && n_poll == 0, "R2 no command", n_er + n_poll, 0);
  endtask

  task automatic t_mixed;
    run_req(5 * 256, 20 * 256, 256, 8, 3, 2, 1'b0);
    chk(saw_done, "R7 mixed range done", int'(saw_done), 1);
    check_frames(5, 20, 8, 2, 3, "R3 R4 mixed frame");
  endtask

  task automatic t_odd_page;
    run_req(16 * 264, 9 * 264, 264, 9, 0, 0, 1'b0);
    chk(saw_done, "R10 264-byte pages done", int'(saw_done), 1);
    check_frames(16, 9, 9, 0, 0, "R10 R3 264 frame");
  endtask

  task automatic t_high_addr;
    run_req(4099 * 1056, 1056, 1056, 11, 5, 3, 1'b0);
    chk(saw_done, "R10 1056-byte page done", int'(saw_done), 1);
    check_frames(4099, 1, 11, 3, 5, "R4 high address frame");
  endtask

  task automatic t_ignore;
    run_req(0, 9 * 512, 512, 9, 1, 1, 1'b1);
    chk(saw_done, "R9 first request done", int'(saw_done), 1);
    check_frames(0, 9, 9, 1, 1, "R9 only first request");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_addr();
    t_bad_len();
    t_zero_len();
    t_mixed();
    t_odd_page();
    t_high_addr();
    t_ignore();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule